// File: doc/BRIEF.md
# Multi-Function GPIO Pin Controller

This block controls a bank of up to 32 general-purpose pins through a small word-addressed register bus. Every pin has a 3-bit function code. The code decides whether the pin is an input, a driven output, or is handed to an alternate peripheral. For alternate functions the block only raises a per-pin select flag; the peripherals themselves sit outside it.

Output values are never written through a data register that software must read, modify and write back. Software writes a mask of ones to a set address or to a clear address, and only the marked pins change. Pin inputs pass through a two-stage synchronizer. The synchronized values can be read as a level word, and they feed rising-edge and falling-edge detectors. Each detector has its own per-pin enable. A detected edge latches into a sticky event word, and software clears that word by writing ones.

Top module: `gpio_bank`

## Requirements
- R1: After reset every function code is 000, the output latch is 0, both edge enables and the event word are 0, and pin_out, pin_oe and alt_en are all 0.
- R2: Function codes sit at word address pin/10 (words 0 to 3), in bits (pin mod 10)*3 +: 3. A write to that word replaces all fields in it, and a read returns them. Bits that belong to no pin read 0.
- R3: pin_oe[n] is 1 exactly when pin n's code is 001, and pin_out[n] equals latch bit n ANDed with pin_oe[n].
- R4: alt_en[n] is 1 exactly when pin n's code is neither 000 (input) nor 001 (output). This covers 100, 011, 010 and the remaining codes.
- R5: A write to address 4 sets every latch bit where the written data has a 1 and leaves the other bits alone. Reading address 4 or 5 returns the latch.
- R6: A write to address 5 clears every latch bit where the written data has a 1 and leaves the other bits alone.
- R7: Address 6 reads the synchronized pin level. A change on pin_in is visible there after the second rising clock edge.
- R8: Address 8 holds the rising-edge enables and address 9 holds the falling-edge enables. Both are writable and read back.
- R9: Address 7 is the event word. Bit n becomes 1 on the third rising clock edge after pin n rises while its rising enable is set, or falls while its falling enable is set. Without the matching enable the bit stays 0. A set bit stays 1 until it is cleared.
- R10: Writing 1 to a bit of address 7 clears that bit, and zero bits are left unchanged. If an edge is latched in the same cycle as the clear, the bit stays 1.
- R11: Addresses 10 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_en |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin |
| alt_en | output | NPINS | Alternate-function select per pin |

## Verification
Two of the block's functions can act on the same event bit in the same cycle: edge latching and the write-one clear. The bench forces this collision. It enables both edge directions on one pin and toggles that pin. It then times a clear write of all ones so that the clear commits on the same rising edge at which the new edge is latched. The bit must read 1 afterwards while every other bit reads 0. A second clear that has no edge beside it must then leave the bit at 0.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] alt_en
);

  localparam logic [3:0] A_SET = 4'd4;
  localparam logic [3:0] A_CLR = 4'd5;
  localparam logic [3:0] A_LEV = 4'd6;
  localparam logic [3:0] A_EVT = 4'd7;
  localparam logic [3:0] A_REN = 4'd8;
  localparam logic [3:0] A_FEN = 4'd9;
  localparam int FWORDS = 4;

  logic [2:0]       fsel [NPINS];
  logic [31:0]      fword [FWORDS];
  logic [NPINS-1:0] out_q, ren_q, fen_q, evt_q;
  logic [NPINS-1:0] sync1, sync2, prev_q, hit;

  wire              wr = bus_en & bus_we;
  wire [NPINS-1:0]  wmask = bus_wdata[NPINS-1:0];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) fsel[p] <= 3'b000;
      else if (wr && bus_addr == 4'(p / 10)) fsel[p] <= bus_wdata[(p % 10) * 3 +: 3];
    assign pin_oe[p] = (fsel[p] == 3'b001);
    assign alt_en[p] = fsel[p][2] | fsel[p][1];
  end

  assign pin_out = out_q & pin_oe;
  assign hit = (sync2 & ~prev_q & ren_q) | (~sync2 & prev_q & fen_q);

  always_comb begin
    for (int w = 0; w < FWORDS; w++) fword[w] = '0;
    for (int p = 0; p < NPINS; p++) fword[p / 10][(p % 10) * 3 +: 3] = fsel[p];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev_q <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      prev_q <= sync2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      evt_q <= '0;
    end else begin
      if (wr && bus_addr == A_SET) out_q <= out_q | wmask;
      else if (wr && bus_addr == A_CLR) out_q <= out_q & ~wmask;
      if (wr && bus_addr == A_REN) ren_q <= wmask;
      if (wr && bus_addr == A_FEN) fen_q <= wmask;
      if (wr && bus_addr == A_EVT) evt_q <= (evt_q & ~wmask) | hit;
      else evt_q <= evt_q | hit;
    end

  always_comb
    case (bus_addr)
      4'd0, 4'd1, 4'd2, 4'd3: bus_rdata = fword[bus_addr[1:0]];
      A_SET, A_CLR:           bus_rdata = 32'(out_q);
      A_LEV:                  bus_rdata = 32'(sync2);
      A_EVT:                  bus_rdata = 32'(evt_q);
      A_REN:                  bus_rdata = 32'(ren_q);
      A_FEN:                  bus_rdata = 32'(fen_q);
      default:                bus_rdata = '0;
    endcase

  // R5
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_SET) |=> ((out_q & $past(wmask)) == $past(wmask)));

  // R6
  clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CLR) |=> ((out_q & $past(wmask)) == '0));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(out_q));

  // R9
  evt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~($past(ren_q) | $past(fen_q))) == '0));

  // R10
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_EVT) |=> ((~evt_q & $past(evt_q)) == '0));

  // R3
  oe_alt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & alt_en) == '0) && ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] pin_in = 0, pin_out, pin_oe, alt_en;
  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  gpio_bank #(.NPINS(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_en(alt_en));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d, model, seed;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, R11 unmapped reads
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      check(a < 10 ? "R1" : "R11", d, 0);
    end
    check("R1 pin_oe", pin_oe, 0);
    check("R1 alt_en", alt_en, 0);
    check("R1 pin_out", pin_out, 0);

    // R2 R3 R4 sweep of every code on every pin
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 8; c++) begin
        wr(4'(p / 10), 32'(c) << ((p % 10) * 3));
        rd(4'(p / 10), d);
        check("R2", d, 32'(c) << ((p % 10) * 3));
        check("R3 oe", pin_oe, (c == 1) ? (32'd1 << p) : 0);
        check("R4 alt", alt_en, (c > 1) ? (32'd1 << p) : 0);
      end
      wr(4'(p / 10), 0);
    end
    for (int w = 0; w < 4; w++) begin
      wr(4'(w), 32'hFFFF_FFFF);
      rd(4'(w), d);
      check("R2 unused", d, (w == 3) ? 32'h3F : 32'h3FFF_FFFF);
    end
    check("R4 all alt", alt_en, 32'hFFFF_FFFF);

    // all pins output
    for (int w = 0; w < 4; w++) wr(4'(w), (w == 3) ? 32'h9 : 32'h0924_9249);
    check("R3 all oe", pin_oe, 32'hFFFF_FFFF);

    // R5 R6 set/clear sequence
    model = 0; seed = 32'h1234_5678;
    for (int i = 0; i < 200; i++) begin
      seed = lcg(seed);
      if (seed[31]) begin wr(4'd4, seed); model = model | seed; end
      else begin wr(4'd5, seed); model = model & ~seed; end
      rd(seed[31] ? 4'd5 : 4'd4, d);
      check(seed[31] ? "R5" : "R6", d, model);
      check("R3 out", pin_out, model);
    end
    wr(4'd4, 0); rd(4'd4, d); check("R5 zero set", d, model);
    wr(4'd5, 0); rd(4'd4, d); check("R6 zero clr", d, model);
    wr(4'd0, 0);
    check("R3 gated", pin_out, model & 32'hFFFF_FC00);
    rd(4'd4, d); check("R5 latch kept", d, model);

    // R7 level timing
    seed = 32'hCAFE_0001;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] old;
      seed = lcg(seed);
      rd(4'd6, old);
      @(negedge clk); pin_in = seed;
      rd(4'd6, d); check("R7 early", d, old);
      rd(4'd6, d); check("R7 level", d, seed);
    end
    @(negedge clk); pin_in = 0;
    repeat (4) @(negedge clk);

    // R8 enables
    wr(4'd8, 32'hA5A5_0F0F); rd(4'd8, d); check("R8 ren", d, 32'hA5A5_0F0F);
    wr(4'd9, 32'h5A5A_F0F0); rd(4'd9, d); check("R8 fen", d, 32'h5A5A_F0F0);

    // R9 per pin, every enable combination
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        wr(4'd8, m[0] ? (32'd1 << p) : 0);
        wr(4'd9, m[1] ? (32'd1 << p) : 0);
        wr(4'd7, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = 32'd1 << p;
        rd(4'd7, d); rd(4'd7, d);
        check("R9 not yet", d, 0);
        rd(4'd7, d);
        check("R9 rise", d, m[0] ? (32'd1 << p) : 0);
        wr(4'd7, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = 0;
        repeat (2) @(negedge clk);
        rd(4'd7, d);
        check("R9 fall", d, m[1] ? (32'd1 << p) : 0);
        rd(4'd7, d);
        check("R9 sticky", d, m[1] ? (32'd1 << p) : 0);
      end
    end

    // R10 partial clear and clear/edge collision
    wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'hF000_000F;
    repeat (3) @(negedge clk);
    rd(4'd7, d); check("R9 multi", d, 32'hF000_000F);
    wr(4'd7, 32'h3000_0003);
    rd(4'd7, d); check("R10 partial", d, 32'hC000_000C);
    @(negedge clk); pin_in = 32'hF000_0007;
    @(negedge clk);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, d); check("R10 edge wins", d, 32'h0000_0008);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, d); check("R10 clear", d, 0);

    // R11 unmapped writes
    for (int a = 10; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    rd(4'd4, d); check("R11 latch", d, model);
    rd(4'd7, d); check("R11 evt", d, 0);
    rd(4'd8, d); check("R11 ren", d, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R11 fsel", d, 0);
    rd(4'd12, d); check("R11 read", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule